// File: doc/BRIEF.md
# Windowed Watchdog Timer with Power-of-Two Postscaler

This block is a watchdog counter that advances on a slow, low-power tick. It is qualified by a tick enable, so it sits in the fast clock domain. A configuration input can force it on. Otherwise software switches it on and off through a small write port. Once running, it counts up towards a period of 32·2^N ticks, where N is a 5-bit postscaler code. Software must service it with a clear strobe before the period expires. If it does not, the block raises a request.

The request depends on the power state. While the system is awake, it is a device reset. While the sleep or idle flag is set, it is a non-maskable wake instead, and nothing is reset. A one-cycle timeout pulse accompanies every request so that a status flag elsewhere can record the event.

An optional late-service window tightens the servicing rule. With the window on, a clear strobe is honoured only in the last part of the period. A clear that comes too early is treated as a fault and requests a reset at once. A debug-halt flag freezes the count. A debug clear and a wake-by-interrupt pulse both restart it.

Top module: `wdog_window`

## Requirements
- R1: With the postscaler code N in 0..20, a counter started from zero with the tick enable held high raises its request on the 32·2^N-th enabled tick. The request appears in the cycle after the edge that takes that tick. The counter then restarts from zero.
- R2: Any postscaler code above 20 (binary 10100) behaves exactly like code 20.
- R3: The window-size code sets the threshold below which a windowed clear is early, as a share of the period P. Code 2'b11 gives 3P/4, 2'b10 gives 5P/8, 2'b01 gives P/2 and 2'b00 gives P/4. The allowed window is therefore 25%, 37.5%, 50% or 75% of the period.
- R4: With the window enabled, a clear strobe sampled while the count is below the threshold raises a reset request in the next cycle. A strobe sampled at or above the threshold is accepted. An accepted strobe restarts the count, so the next timeout follows one full period after that edge.
- R5: With the window disabled, a clear strobe at any count before the timeout is accepted and restarts the count.
- R6: A timeout while sleep_mode or idle_mode is high raises nmi_wake and not rst_req. Entering a low-power mode does not restart the count.
- R7: A dbg_clr pulse or a wake_irq pulse restarts the count from zero.
- R8: While dbg_halt is high, the count does not advance and no timeout occurs. Counting resumes from the held value when dbg_halt falls.
- R9: en_stat is cfg_force_en OR a software enable bit. The software enable bit is written by sw_en_wr with sw_en_val, is cleared by reset, and is unaffected by wake_irq. While en_stat is low, the count stays at zero and neither clear strobes nor ticks produce any request.
- R10: rst_req and nmi_wake are single-cycle pulses that are never high together. tmo_pulse is high in exactly the cycles in which one of them is high.
- R11: During reset, all three request outputs are low, and en_stat follows cfg_force_en alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle qualifier per slow tick |
| cfg_force_en | input | 1 | Configuration-forced enable |
| sw_en_wr | input | 1 | Write strobe for the software enable bit |
| sw_en_val | input | 1 | Value written to the software enable bit |
| ps_code | input | 5 | Postscaler code N, period 32·2^N ticks |
| win_en | input | 1 | Late-service window enable |
| win_size | input | 2 | Window-size code |
| clr_req | input | 1 | Service (clear) strobe |
| sleep_mode | input | 1 | Sleep state flag |
| idle_mode | input | 1 | Idle state flag |
| dbg_halt | input | 1 | Debug halt, freezes the count |
| dbg_clr | input | 1 | Debug clear command |
| wake_irq | input | 1 | Wake-by-interrupt pulse |
| rst_req | output | 1 | Device reset request pulse |
| nmi_wake | output | 1 | Non-maskable wake request pulse |
| tmo_pulse | output | 1 | Watchdog event pulse for a status flag |
| en_stat | output | 1 | Effective enable readback |

## Verification
A counter that drifts, clears at the wrong moment or decodes the postscaler wrongly shows up as a request pulse on the wrong edge. For the short periods used here, that shift is visible within tens of cycles. A wrong window threshold shifts the boundary between an early-clear reset and an accepted clear by the misplaced count. The bench therefore probes the clear strobe one count below and exactly at each threshold. A swapped power-state decode shows as the wrong output pulsing on the expected edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Window-size encodings: allowed share of the period before the match
  typedef enum logic [1:0] {
    WS_75  = 2'b00,
    WS_50  = 2'b01,
    WS_375 = 2'b10,
    WS_25  = 2'b11
  } win_size_e;

  localparam int unsigned BASE_W_DEF = 5;   // 32 ticks base period
  localparam int unsigned PS_MAX_DEF = 20;  // largest postscaler exponent
  localparam int unsigned PS_W_DEF   = 5;
endpackage

// File: rtl/wdog_limits.sv
module wdog_limits #(
  parameter int unsigned BASE_W = 5,
  parameter int unsigned PS_MAX = 20,
  parameter int unsigned PS_W   = 5,
  parameter int unsigned CNT_W  = BASE_W + PS_MAX
) (
  input  logic [PS_W-1:0]  ps_code,
  input  logic [1:0]       win_size,
  output logic [CNT_W-1:0] lim,
  output logic [CNT_W-1:0] thr
);
  import wdog_pkg::*;
  localparam int unsigned PER_W = CNT_W + 1;

  logic [PS_W-1:0]  n_eff;
  logic [PER_W-1:0] per;
  logic [PER_W-1:0] quarter;
  logic [PER_W-1:0] eighth;
  logic [PER_W-1:0] thr_w;

  assign n_eff   = (ps_code > PS_W'(PS_MAX)) ? PS_W'(PS_MAX) : ps_code;
  assign per     = PER_W'(1) << (int'(n_eff) + int'(BASE_W));
  assign quarter = per >> 2;
  assign eighth  = per >> 3;
  assign lim     = CNT_W'(per - PER_W'(1));

  always_comb begin
    unique case (win_size_e'(win_size))
      WS_25:   thr_w = per - quarter;
      WS_375:  thr_w = per - quarter - eighth;
      WS_50:   thr_w = per >> 1;
      default: thr_w = quarter;
    endcase
  end

  assign thr = CNT_W'(thr_w);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned BASE_W = 5,
  parameter int unsigned PRE_W  = 20,
  parameter int unsigned CNT_W  = BASE_W + PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [CNT_W-1:0] cnt
);
  logic [BASE_W-1:0] base_q, base_d;
  logic [PRE_W-1:0]  pre_q,  pre_d;
  logic              carry;

  assign carry = &base_q;

  always_comb begin
    base_d = base_q;
    pre_d  = pre_q;
    if (clr) begin
      base_d = '0;
      pre_d  = '0;
    end else if (step) begin
      base_d = base_q + BASE_W'(1);
      if (carry) pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      pre_q  <= '0;
    end else begin
      base_q <= base_d;
      pre_q  <= pre_d;
    end
  end

  assign cnt = {pre_q, base_q};
endmodule

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int unsigned BASE_W = wdog_pkg::BASE_W_DEF,
  parameter int unsigned PS_MAX = wdog_pkg::PS_MAX_DEF,
  parameter int unsigned PS_W   = wdog_pkg::PS_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            cfg_force_en,
  input  logic            sw_en_wr,
  input  logic            sw_en_val,
  input  logic [PS_W-1:0] ps_code,
  input  logic            win_en,
  input  logic [1:0]      win_size,
  input  logic            clr_req,
  input  logic            sleep_mode,
  input  logic            idle_mode,
  input  logic            dbg_halt,
  input  logic            dbg_clr,
  input  logic            wake_irq,
  output logic            rst_req,
  output logic            nmi_wake,
  output logic            tmo_pulse,
  output logic            en_stat
);
  localparam int unsigned CNT_W = BASE_W + PS_MAX;

  // reset synchronizer: asynchronous assert, synchronous release
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic [CNT_W-1:0] cnt, lim, thr;
  logic en, en_sw_q, en_sw_d;
  logic lowpwr, step, early, clr_ok, tmo, cnt_clr;
  logic rst_d, nmi_d, tmo_d;
  logic rst_q, nmi_q, tmo_q;

  wdog_limits #(
    .BASE_W(BASE_W), .PS_MAX(PS_MAX), .PS_W(PS_W), .CNT_W(CNT_W)
  ) u_lim (
    .ps_code (ps_code),
    .win_size(win_size),
    .lim     (lim),
    .thr     (thr)
  );

  wdog_counter #(
    .BASE_W(BASE_W), .PRE_W(PS_MAX), .CNT_W(CNT_W)
  ) u_cnt (
    .clk  (clk),
    .rst_n(rst_s2),
    .clr  (cnt_clr),
    .step (step),
    .cnt  (cnt)
  );

  // next-state logic
  always_comb begin
    en_sw_d = sw_en_wr ? sw_en_val : en_sw_q;
    en      = cfg_force_en | en_sw_q;
    lowpwr  = sleep_mode | idle_mode;
    step    = en & tick_en & ~dbg_halt;
    early   = en & clr_req & win_en & (cnt < thr);
    clr_ok  = en & clr_req & ~early;
    tmo     = step & (cnt == lim) & ~clr_req;
    cnt_clr = ~en | clr_ok | early | dbg_clr | wake_irq | tmo;
    rst_d   = (tmo & ~lowpwr) | early;
    nmi_d   = tmo & lowpwr;
    tmo_d   = tmo | early;
  end

  // registers
  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      en_sw_q <= 1'b0;
      rst_q   <= 1'b0;
      nmi_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      en_sw_q <= en_sw_d;
      rst_q   <= rst_d;
      nmi_q   <= nmi_d;
      tmo_q   <= tmo_d;
    end
  end

  assign rst_req   = rst_q;
  assign nmi_wake  = nmi_q;
  assign tmo_pulse = tmo_q;
  assign en_stat   = en;
endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_force_en,
  input logic clr_req,
  input logic sleep_mode,
  input logic idle_mode,
  input logic dbg_halt,
  input logic rst_req,
  input logic nmi_wake,
  input logic tmo_pulse,
  input logic en_stat
);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_req, nmi_wake}));

  a_r10_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r10_nmi_single: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_wake |=> !nmi_wake);

  a_r10_flag_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |-> (rst_req || nmi_wake));

  a_r6_nmi_lowpwr: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_wake |-> $past(sleep_mode || idle_mode));

  a_r8_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dbg_halt) && !$past(clr_req)) |-> !tmo_pulse);

  a_r9_forced_on: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_force_en |-> en_stat);

  a_r9_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_stat) |-> !tmo_pulse);
endmodule

bind wdog_window wdog_window_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_force_en(cfg_force_en),
  .clr_req     (clr_req),
  .sleep_mode  (sleep_mode),
  .idle_mode   (idle_mode),
  .dbg_halt    (dbg_halt),
  .rst_req     (rst_req),
  .nmi_wake    (nmi_wake),
  .tmo_pulse   (tmo_pulse),
  .en_stat     (en_stat)
);

// File: tb/tb_wdog_window.sv
`timescale 1ns/1ps
module tb_wdog_window;
  logic clk = 1'b0;
  logic rst_n;
  logic tick_en, cfg_force_en, sw_en_wr, sw_en_val;
  logic [4:0] ps_code;
  logic win_en;
  logic [1:0] win_size;
  logic clr_req, sleep_mode, idle_mode, dbg_halt, dbg_clr, wake_irq;
  logic rst_req, nmi_wake, tmo_pulse, en_stat;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdog_window dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_force_en(cfg_force_en),
    .sw_en_wr(sw_en_wr), .sw_en_val(sw_en_val), .ps_code(ps_code),
    .win_en(win_en), .win_size(win_size), .clr_req(clr_req),
    .sleep_mode(sleep_mode), .idle_mode(idle_mode), .dbg_halt(dbg_halt),
    .dbg_clr(dbg_clr), .wake_irq(wake_irq), .rst_req(rst_req),
    .nmi_wake(nmi_wake), .tmo_pulse(tmo_pulse), .en_stat(en_stat)
  );

  // kind: 1 = reset request, 2 = wake request
  typedef struct packed {
    logic [4:0]  ps;
    logic [1:0]  ws;
    logic        win;
    logic [1:0]  lp;    // 0 awake, 1 sleep, 2 idle
    logic [15:0] clr;   // clear strobe after this edge, 0 = none
    logic [1:0]  kind;
    logic [15:0] edge_n;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{5'd0,  2'b00, 1'b0, 2'd0, 16'd0,  2'd1, 16'd32,  4'd1},
    '{5'd1,  2'b00, 1'b0, 2'd0, 16'd0,  2'd1, 16'd64,  4'd1},
    '{5'd3,  2'b00, 1'b0, 2'd0, 16'd0,  2'd1, 16'd256, 4'd1},
    '{5'd0,  2'b00, 1'b0, 2'd0, 16'd5,  2'd1, 16'd38,  4'd5},
    '{5'd0,  2'b11, 1'b1, 2'd0, 16'd23, 2'd1, 16'd24,  4'd4},
    '{5'd0,  2'b11, 1'b1, 2'd0, 16'd24, 2'd1, 16'd57,  4'd4},
    '{5'd0,  2'b10, 1'b1, 2'd0, 16'd19, 2'd1, 16'd20,  4'd3},
    '{5'd0,  2'b10, 1'b1, 2'd0, 16'd20, 2'd1, 16'd53,  4'd3},
    '{5'd0,  2'b01, 1'b1, 2'd0, 16'd15, 2'd1, 16'd16,  4'd3},
    '{5'd0,  2'b01, 1'b1, 2'd0, 16'd16, 2'd1, 16'd49,  4'd3},
    '{5'd0,  2'b00, 1'b1, 2'd0, 16'd7,  2'd1, 16'd8,   4'd3},
    '{5'd0,  2'b00, 1'b1, 2'd0, 16'd8,  2'd1, 16'd41,  4'd3},
    '{5'd2,  2'b11, 1'b1, 2'd0, 16'd95, 2'd1, 16'd96,  4'd4},
    '{5'd2,  2'b11, 1'b1, 2'd0, 16'd96, 2'd1, 16'd225, 4'd4},
    '{5'd0,  2'b00, 1'b0, 2'd1, 16'd0,  2'd2, 16'd32,  4'd6},
    '{5'd0,  2'b00, 1'b0, 2'd2, 16'd0,  2'd2, 16'd32,  4'd6},
    '{5'd20, 2'b00, 1'b1, 2'd0, 16'd50, 2'd1, 16'd51,  4'd2},
    '{5'd31, 2'b00, 1'b1, 2'd0, 16'd50, 2'd1, 16'd51,  4'd2}
  };

  function automatic string tag_of(input logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick_en = 1'b1; cfg_force_en = 1'b0; sw_en_wr = 1'b0; sw_en_val = 1'b0;
    ps_code = '0; win_en = 1'b0; win_size = '0; clr_req = 1'b0;
    sleep_mode = 1'b0; idle_mode = 1'b0; dbg_halt = 1'b0; dbg_clr = 1'b0;
    wake_irq = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  // evt: 0 none, 1 debug clear, 2 wake by interrupt, 3 enter sleep
  task automatic run_case(input int ps, input int ws, input int win, input int lp,
                          input int clr_at, input int evt, input int evt_at,
                          input int h_at, input int h_len, input int ek,
                          input int ee, input string req);
    int e;
    int got_e;
    int got_k;
    int got_t;
    do_reset();
    ps_code = ps[4:0]; win_size = ws[1:0]; win_en = win[0];
    sleep_mode = (lp == 1); idle_mode = (lp == 2);
    sw_en_wr = 1'b1; sw_en_val = 1'b1;
    @(posedge clk);
    #1 sw_en_wr = 1'b0;
    e = 0; got_e = -1; got_k = 0; got_t = 0;
    while (got_e < 0 && e < ee + 20) begin
      clr_req  = (clr_at != 0 && e == clr_at);
      dbg_clr  = (evt == 1 && e == evt_at);
      wake_irq = (evt == 2 && e == evt_at);
      if (evt == 3 && e == evt_at) sleep_mode = 1'b1;
      dbg_halt = (h_len > 0 && e >= h_at && e < h_at + h_len);
      @(posedge clk);
      #1;
      e++;
      if (rst_req || nmi_wake) begin
        got_e = e;
        got_k = rst_req ? 1 : 2;
        got_t = int'(tmo_pulse);
      end
    end
    clr_req = 1'b0; dbg_clr = 1'b0; wake_irq = 1'b0; dbg_halt = 1'b0;
    chk(got_e == ee, req, "request edge", got_e, ee);
    chk(got_k == ek, req, "request kind", got_k, ek);
    chk(got_t == 1, "R10", "timeout flag with request", got_t, 1);
    @(posedge clk);
    #1;
    chk(!rst_req && !nmi_wake && !tmo_pulse, "R10", "pulse width one cycle",
        int'(rst_req) + int'(nmi_wake) + int'(tmo_pulse), 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int pulses;
    // R11: reset state
    rst_n = 1'b0;
    tick_en = 1'b1; cfg_force_en = 1'b0; sw_en_wr = 1'b0; sw_en_val = 1'b0;
    ps_code = '0; win_en = 1'b0; win_size = '0; clr_req = 1'b0;
    sleep_mode = 1'b0; idle_mode = 1'b0; dbg_halt = 1'b0; dbg_clr = 1'b0;
    wake_irq = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(!rst_req && !nmi_wake && !tmo_pulse, "R11", "outputs in reset",
        int'(rst_req) + int'(nmi_wake) + int'(tmo_pulse), 0);
    chk(en_stat == 1'b0, "R11", "enable in reset", int'(en_stat), 0);
    cfg_force_en = 1'b1;
    #1;
    chk(en_stat == 1'b1, "R11", "forced enable in reset", int'(en_stat), 1);

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      run_case(int'(VEC[i].ps), int'(VEC[i].ws), int'(VEC[i].win),
               int'(VEC[i].lp), int'(VEC[i].clr), 0, 0, 0, 0,
               int'(VEC[i].kind), int'(VEC[i].edge_n), tag_of(VEC[i].tag));
    end

    // R8: halt for 100 edges from count 10 delays the timeout by 100
    run_case(0, 0, 0, 0, 0, 0, 0, 10, 100, 1, 132, "R8");
    // R7: debug clear and wake by interrupt restart the count
    run_case(0, 0, 0, 0, 0, 1, 20, 0, 0, 1, 53, "R7");
    run_case(0, 0, 0, 0, 0, 2, 20, 0, 0, 1, 53, "R7");
    // R9: software enable survives a wake pulse
    chk(en_stat == 1'b1, "R9", "enable kept after wake", int'(en_stat), 1);
    // R6: entering sleep mid-period does not restart the count
    run_case(0, 0, 0, 0, 0, 3, 20, 0, 0, 2, 32, "R6");

    // R9: forced enable cannot be cleared by software
    do_reset();
    cfg_force_en = 1'b1;
    sw_en_wr = 1'b1; sw_en_val = 1'b0;
    @(posedge clk);
    #1 sw_en_wr = 1'b0;
    chk(en_stat == 1'b1, "R9", "forced enable after sw clear", int'(en_stat), 1);
    cfg_force_en = 1'b0;
    #1;
    chk(en_stat == 1'b0, "R9", "sw bit stays cleared", int'(en_stat), 0);

    // R9: disabled block ignores ticks and early clears
    do_reset();
    win_en = 1'b1; win_size = 2'b11;
    pulses = 0;
    for (int k = 0; k < 100; k++) begin
      clr_req = k[0];
      @(posedge clk);
      #1;
      if (rst_req || nmi_wake || tmo_pulse) pulses++;
    end
    clr_req = 1'b0;
    chk(pulses == 0, "R9", "requests while disabled", pulses, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule